// File: doc/BRIEF.md
# Dual-Channel Light Result Register Bank

This block is the read side of a two-channel light converter's register space. A host reaches it through a simple byte-addressed read port. Every read request gets a response exactly one cycle later. The bank holds a constant identification byte and the two latest 16-bit conversion results. The converter core supplies these results through per-channel update strobes.

Each 16-bit result is presented as a pair of byte registers. A host that reads a pair one byte at a time could see the low half of one conversion and the high half of the next. To prevent this, every low-byte read also copies the live high byte into a per-channel shadow register. The matching high-byte read then returns that shadow. A word-mode read at a low-byte address returns the whole live result in one response.

The write port is present but has no effect, because the bank is read-only.

Top module: `lrb_top`

## Requirements
- R1: A read of address 0x12 returns the identification byte {4'b1001, revision}. With the default revision of 4'h1 this is 0x91, and it never changes.
- R2: Channel 0 low and high bytes sit at 0x14 and 0x15, and channel 1 low and high bytes sit at 0x16 and 0x17. A byte read returns its value on rsp_data[7:0] with rsp_data[15:8] = 0x00. rsp_valid is high in exactly the cycle after each cycle with rd_req high, and low otherwise.
- R3: After reset, every result byte and every shadow byte reads 0x00.
- R4: A low-byte read returns the live low byte. In the same cycle it copies the live high byte into that channel's shadow register.
- R5: A high-byte read returns the channel's shadow register. This holds even if the live result has been updated one or more times since the low-byte read.
- R6: A low-byte read on one channel leaves the other channel's shadow unchanged.
- R7: A word read (rd_word = 1) at a low-byte address returns the full live result, with the high byte on rsp_data[15:8] and the low byte on rsp_data[7:0]. Like a byte read, it also loads the shadow. A word read at any other address returns the same value as a byte read there.
- R8: A high-byte read with no earlier low-byte read on that channel returns the shadow's current contents, which are 0x00 after reset.
- R9: Reads of unmapped addresses (anything other than 0x12 and 0x14 to 0x17) return 0x0000. Writes to any address change no readable value.
- R10: If an update strobe and a low-byte read of the same channel fall in one cycle, both the returned low byte and the captured shadow come from the value held before the update.
- R11: An update strobe loads the channel's live result from cv_res. Without a strobe, the live result holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, one cycle per access |
| rd_addr | input | 8 | Read address |
| rd_word | input | 1 | Word-mode read |
| wr_req | input | 1 | Write request (ignored) |
| wr_addr | input | 8 | Write address (ignored) |
| wr_data | input | 8 | Write data (ignored) |
| cv_upd | input | 2 | Per-channel result update strobe |
| cv_res | input | 32 | Per-channel new result, channel c in bits [16c+15:16c] |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Read response data |

## Verification
Two functions can fall in the same cycle: a conversion update from the core and a host low-byte read of that same channel. The bench provokes this by raising the update strobe with a new value in the very cycle it issues the low-byte read. It expects the response to carry the old low byte. It then reads the high byte and expects the old high byte, and a second low-byte read must show the new value. The checker judges the same collision cycle by cycle, comparing the response and the shadow against the live value from the previous cycle.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int ADDR_W  = 8;
  localparam int BYTE_W  = 8;
  localparam int CHIDX_W = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e          kind;
    logic [CHIDX_W-1:0] ch;
  } sel_t;

  // Address of the low byte of channel ch, pairs packed upward from base.
  function automatic logic [ADDR_W-1:0] lo_addr(input logic [ADDR_W-1:0] base,
                                                input int unsigned ch);
    return base + ADDR_W'(2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input logic [ADDR_W-1:0] base,
                                                input int unsigned ch);
    return lo_addr(base, ch) + ADDR_W'(1);
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic [3:0] part,
                                                input logic [3:0] rev);
    return {part, rev};
  endfunction

  function automatic logic [2*BYTE_W-1:0] byte_pad(input logic [BYTE_W-1:0] b);
    return {{BYTE_W{1'b0}}, b};
  endfunction
endpackage

// File: rtl/lrb_decode.sv
module lrb_decode
  import lrb_pkg::*;
#(
  parameter int               NUM_CH    = 2,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 8'h12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel,
  output logic [NUM_CH-1:0] lo_hit
);
  always_comb begin
    sel.kind = SEL_NONE;
    sel.ch   = '0;
    if (addr == ID_ADDR) begin
      sel.kind = SEL_ID;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == lo_addr(BASE_ADDR, c)) begin
        sel.kind = SEL_LO;
        sel.ch   = CHIDX_W'(c);
      end
      if (addr == hi_addr(BASE_ADDR, c)) begin
        sel.kind = SEL_HI;
        sel.ch   = CHIDX_W'(c);
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign lo_hit[g] = req && (sel.kind == SEL_LO) && (sel.ch == CHIDX_W'(g));
  end
endmodule

// File: rtl/lrb_channel.sv
module lrb_channel
  import lrb_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [RES_W-1:0]  res,
  input  logic              snap,
  output logic [RES_W-1:0]  live,
  output logic [BYTE_W-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
    end else begin
      if (upd)  live   <= res;
      // Non-blocking: the capture sees the value held before any same-cycle update.
      if (snap) shadow <= live[RES_W-1:RES_W-BYTE_W];
    end
  end
endmodule

// File: rtl/lrb_readmux.sv
module lrb_readmux
  import lrb_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int RES_W  = 16
) (
  input  sel_t                           sel,
  input  logic                           word,
  input  logic [BYTE_W-1:0]              id_val,
  input  logic [NUM_CH-1:0][RES_W-1:0]   live,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  shadow,
  output logic [RES_W-1:0]               data
);
  always_comb begin
    data = '0;
    case (sel.kind)
      SEL_ID: data = byte_pad(id_val);
      SEL_LO: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (sel.ch == CHIDX_W'(c)) begin
            data = word ? live[c] : byte_pad(live[c][BYTE_W-1:0]);
          end
        end
      end
      SEL_HI: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (sel.ch == CHIDX_W'(c)) data = byte_pad(shadow[c]);
        end
      end
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/lrb_top.sv
module lrb_top
  import lrb_pkg::*;
#(
  parameter int               NUM_CH    = 2,
  parameter int               RES_W     = 16,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 8'h12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14,
  parameter logic [3:0]        PART_NO   = 4'b1001,
  parameter logic [3:0]        REV_NO    = 4'h1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    rd_word,
  input  logic                    wr_req,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [NUM_CH-1:0]       cv_upd,
  input  logic [NUM_CH*RES_W-1:0] cv_res,
  output logic                    rsp_valid,
  output logic [RES_W-1:0]        rsp_data
);
  localparam logic [BYTE_W-1:0] ID_VAL = id_byte(PART_NO, REV_NO);

  sel_t                          sel;
  logic [NUM_CH-1:0]             lo_hit;
  logic [NUM_CH-1:0][RES_W-1:0]  live;
  logic [NUM_CH-1:0][BYTE_W-1:0] shadow;
  logic [RES_W-1:0]              rd_val;

  lrb_decode #(
    .NUM_CH(NUM_CH), .ID_ADDR(ID_ADDR), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .req(rd_req), .addr(rd_addr), .sel(sel), .lo_hit(lo_hit)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lrb_channel #(.RES_W(RES_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (cv_upd[g]),
      .res   (cv_res[g*RES_W +: RES_W]),
      .snap  (lo_hit[g]),
      .live  (live[g]),
      .shadow(shadow[g])
    );
  end

  lrb_readmux #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_mux (
    .sel(sel), .word(rd_word), .id_val(ID_VAL),
    .live(live), .shadow(shadow), .data(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_data  <= rd_req ? rd_val : '0;
    end
  end
endmodule

// File: rtl/lrb_chk.sv
module lrb_chk
  import lrb_pkg::*;
#(
  parameter int               NUM_CH    = 2,
  parameter int               RES_W     = 16,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 8'h12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14,
  parameter logic [3:0]        PART_NO   = 4'b1001,
  parameter logic [3:0]        REV_NO    = 4'h1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rd_req,
  input logic [ADDR_W-1:0]             rd_addr,
  input logic                          rd_word,
  input logic                          wr_req,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [BYTE_W-1:0]             wr_data,
  input logic [NUM_CH-1:0]             cv_upd,
  input logic [NUM_CH*RES_W-1:0]       cv_res,
  input logic [NUM_CH-1:0]             lo_hit,
  input logic [NUM_CH-1:0][RES_W-1:0]  live,
  input logic [NUM_CH-1:0][BYTE_W-1:0] shadow,
  input logic                          rsp_valid,
  input logic [RES_W-1:0]              rsp_data
);
  localparam int TOP_END = int'(BASE_ADDR) + 2 * NUM_CH;

  logic unmapped;
  assign unmapped = (rd_addr != ID_ADDR) &&
                    ((int'(rd_addr) < int'(BASE_ADDR)) || (int'(rd_addr) >= TOP_END));

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid); // R2
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == ID_ADDR) |=> rsp_data == {8'h00, PART_NO, REV_NO}); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && unmapped) |=> rsp_data == '0); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    localparam logic [ADDR_W-1:0] LO = BASE_ADDR + ADDR_W'(2 * g);
    localparam logic [ADDR_W-1:0] HI = LO + ADDR_W'(1);

    AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      lo_hit[g] |=> shadow[g] == $past(live[g][RES_W-1:RES_W-BYTE_W])); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_hit[g] |=> $stable(shadow[g])); // R6
    AST_LO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_addr == LO && !rd_word) |=>
        rsp_data == {8'h00, $past(live[g][BYTE_W-1:0])}); // R10
    AST_HI_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_addr == HI) |=> rsp_data == {8'h00, $past(shadow[g])}); // R5
    AST_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_addr == LO && rd_word) |=> rsp_data == $past(live[g])); // R7
    AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cv_upd[g] |=> live[g] == $past(cv_res[g*RES_W +: RES_W])); // R11
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cv_upd[g] |=> $stable(live[g])); // R11
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_addr == LO && wr_data != live[g][BYTE_W-1:0] && !cv_upd[g]) |=>
        live[g][BYTE_W-1:0] == $past(live[g][BYTE_W-1:0])); // R9
  end
endmodule

bind lrb_top lrb_chk #(
  .NUM_CH(NUM_CH), .RES_W(RES_W), .ID_ADDR(ID_ADDR), .BASE_ADDR(BASE_ADDR),
  .PART_NO(PART_NO), .REV_NO(REV_NO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_word(rd_word),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
  .cv_upd(cv_upd), .cv_res(cv_res), .lo_hit(lo_hit), .live(live), .shadow(shadow),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/test_lrb_top.sv
`timescale 1ns/1ps
module test_lrb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        rd_word = 1'b0;
  logic        wr_req = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  cv_upd = '0;
  logic [31:0] cv_res = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  always #4 clk = ~clk;

  lrb_top i_lrb_top (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_word(rd_word),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .cv_upd(cv_upd), .cv_res(cv_res), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] m_live [2];
  logic [7:0]  m_sh   [2];

  // Expected read value derived from the requirement text, not from the design.
  function automatic logic [15:0] model_read(input logic [7:0] a, input logic w);
    if (a == 8'h12) return 16'h0091;                              // R1
    if (a == 8'h14) return w ? m_live[0] : {8'h00, m_live[0][7:0]};
    if (a == 8'h16) return w ? m_live[1] : {8'h00, m_live[1][7:0]};
    if (a == 8'h15) return {8'h00, m_sh[0]};
    if (a == 8'h17) return {8'h00, m_sh[1]};
    return 16'h0000;                                              // R9
  endfunction

  task automatic push_read(input logic [7:0] a, input logic w, input string tag);
    item_t it;
    it.exp = model_read(a, w);
    it.tag = tag;
    sb.push_back(it);
    if (a == 8'h14) m_sh[0] = m_live[0][15:8];
    if (a == 8'h16) m_sh[1] = m_live[1][15:8];
    rd_req  = 1'b1;
    rd_addr = a;
    rd_word = w;
  endtask

  task automatic do_read(input logic [7:0] a, input logic w, input string tag);
    @(negedge clk);
    push_read(a, w, tag);
    @(negedge clk);
    rd_req  = 1'b0;
    rd_word = 1'b0;
  endtask

  task automatic do_upd(input int c, input logic [15:0] v);
    @(negedge clk);
    cv_upd[c]            = 1'b1;
    cv_res[c*16 +: 16]   = v;
    @(negedge clk);
    cv_upd   = '0;
    m_live[c] = v;
  endtask

  // R10: update strobe and low-byte read of the same channel in one cycle.
  task automatic do_read_upd(input int c, input logic [15:0] v, input string tag);
    @(negedge clk);
    push_read(c == 0 ? 8'h14 : 8'h16, 1'b0, tag);
    cv_upd[c]          = 1'b1;
    cv_res[c*16 +: 16] = v;
    @(negedge clk);
    rd_req    = 1'b0;
    cv_upd    = '0;
    m_live[c] = v;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_req  = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_req  = 1'b0;
  endtask

  // Monitor: pop and compare each response as it appears.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected response: actual %h expected none", rsp_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rsp_data !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, rsp_data, it.exp);
        end
      end
    end
  end

  task automatic finish_run;
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_live[0] = '0; m_live[1] = '0; m_sh[0] = '0; m_sh[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 / R8: reset values, high bytes read before any low read
    do_read(8'h15, 1'b0, "R8 hi before lo ch0");
    do_read(8'h17, 1'b0, "R8 hi before lo ch1");
    do_read(8'h14, 1'b0, "R3 reset ch0 lo");
    do_read(8'h16, 1'b0, "R3 reset ch1 lo");
    do_read(8'h15, 1'b0, "R3 reset ch0 hi");
    do_read(8'h16, 1'b1, "R3 reset ch1 word");

    // R1: identification byte, byte and word mode
    do_read(8'h12, 1'b0, "R1 id");
    do_read(8'h12, 1'b1, "R1 id word");

    // R11 / R2 / R4: update then ordered byte reads
    do_upd(0, 16'hA1B2);
    do_upd(1, 16'hC3D4);
    do_read(8'h14, 1'b0, "R4 ch0 lo");
    do_read(8'h15, 1'b0, "R2 ch0 hi");
    do_read(8'h16, 1'b0, "R11 ch1 lo");
    do_read(8'h17, 1'b0, "R2 ch1 hi");

    // R5: shadow survives several updates between the byte reads
    do_read(8'h14, 1'b0, "R5 ch0 lo");
    do_upd(0, 16'h5566);
    do_upd(0, 16'h7788);
    do_read(8'h15, 1'b0, "R5 ch0 hi after updates");
    do_read(8'h14, 1'b0, "R11 ch0 lo new");
    do_read(8'h15, 1'b0, "R5 ch0 hi new");

    // R6: channel independence of shadows
    do_upd(1, 16'h0F1E);
    do_read(8'h16, 1'b0, "R6 ch1 lo");
    do_read(8'h14, 1'b0, "R6 ch0 lo");
    do_upd(0, 16'h9900);
    do_read(8'h17, 1'b0, "R6 ch1 hi untouched");
    do_read(8'h15, 1'b0, "R6 ch0 hi");

    // R7: word reads
    do_read(8'h14, 1'b1, "R7 word ch0");
    do_read(8'h16, 1'b1, "R7 word ch1");
    do_upd(1, 16'h2468);
    do_read(8'h17, 1'b0, "R7 word loads shadow");
    do_read(8'h15, 1'b1, "R7 word at hi addr");

    // R9: unmapped reads and ignored writes
    do_read(8'h00, 1'b0, "R9 unmapped 00");
    do_read(8'h13, 1'b0, "R9 unmapped 13");
    do_read(8'h18, 1'b1, "R9 unmapped 18");
    do_read(8'hFF, 1'b0, "R9 unmapped FF");
    do_write(8'h14, 8'h5A);
    do_write(8'h15, 8'hA5);
    do_write(8'h12, 8'h00);
    do_read(8'h14, 1'b1, "R9 write ignored ch0");
    do_read(8'h12, 1'b0, "R9 write ignored id");
    do_read(8'h15, 1'b0, "R9 write ignored shadow");

    // R10: same-cycle update and low read on each channel
    do_read_upd(0, 16'hBEEF, "R10 ch0 lo old value");
    do_read(8'h15, 1'b0, "R10 ch0 hi old value");
    do_read(8'h14, 1'b0, "R10 ch0 lo new value");
    do_read_upd(1, 16'hCAFE, "R10 ch1 lo old value");
    do_read(8'h17, 1'b0, "R10 ch1 hi old value");
    do_read(8'h16, 1'b1, "R10 ch1 word new value");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule